// File: doc/BRIEF.md
# Exception Entry Vector Unit

This unit carries out the hardware side of taking a general exception in a control coprocessor. A single-cycle strobe delivers the exception class, an exception code, the PC at which the fault was seen, a delay-slot flag, the faulting virtual address and whether the access was a store. On the clock edge of that strobe the unit picks a vector offset and a vector base, forms the new PC, and updates its own Status, Cause, EPC, BadVAddr, Context and EntryHi state. It also holds IntCtl and EBase.

The vector depends on several inputs: whether an earlier exception is still being handled, the class of the exception, the interrupt-vector bit of Cause, and whether the boot vectors are selected. The new PC keeps the two top bits of the base and adds the offset only into the lower 30 bits. TLB-type faults also load the faulting address into the address-capture registers. A small software port reads and writes the eight registers. In a strobe cycle the exception update takes precedence over that port.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset, Status reads 0x0040_0000 (boot-vector bit 22 set, EXL bit 1 clear), every other register reads 0, `new_pc_o` is 0xBFC0_0000 and `new_pc_valid_o` is 0.
- R2: All updates caused by a strobe take effect on that strobe's clock edge. `new_pc_valid_o` is 1 for exactly the cycle after each strobe and 0 otherwise.
- R3: When Status bit 1 (EXL) is 0 at the strobe, EPC becomes PC-8 and Cause bit 31 (BD) becomes 1 if `in_delay_slot_i` is set. Otherwise EPC becomes PC-4 and BD is cleared.
- R4: When EXL is already 1 at the strobe, the offset is 0x180 for every class, and EPC and BD keep their values.
- R5: With EXL 0, the offset depends on `exc_class_i` (0 general, 1 TLB refill, 2 interrupt). Refill uses 0x000 and general uses 0x180. An interrupt uses 0x180 when Cause bit 23 (IV) is 0 and 0x200 when IV is 1, whatever Status bit 22 and the IntCtl spacing field bits 9:5 hold.
- R6: The base is 0xBFC0_0200 when Status bit 22 is 1. Otherwise the base is EBase bits 31:12 with bits 11:0 zero.
- R7: `new_pc_o[31:30]` equals base bits 31:30, and `new_pc_o[29:0]` is the low 30 bits of base[29:0] plus offset.
- R8: Every strobe sets EXL. It replaces Cause bits 6:2 with the resolved code and leaves Cause bit 23 and bits 9:8 unchanged.
- R9: Cause bits 29:28 become `cu_unit_i` when the resolved code is 11 (coprocessor unusable), and 0 for every other code.
- R10: The code is resolved from `fault_kind_i`. Kind 0 passes `exc_code_i`. Kind 1 (TLB miss) gives 3 on a store and 2 on a load. Kind 2 (TLB modified) gives 1. Kind 3 (read inhibit) gives 19 when `page_iec_i` is 1 and 2 otherwise. Kind 4 (execute inhibit) gives 20 when `page_iec_i` is 1 and 2 otherwise.
- R11: Kinds 1, 2 and 3 load `fault_va_i` into BadVAddr; kind 4 leaves BadVAddr unchanged. Kinds 1 to 4 copy VA bits 31:13 into Context bits 22:4 and into EntryHi bits 31:13 and keep every other bit of Context and EntryHi.
- R12: `sw_sel_i` selects the register: 0 Status, 1 Cause, 2 IntCtl, 3 EBase, 4 EPC, 5 BadVAddr, 6 Context, 7 EntryHi. Reads return the stored value in the same cycle. Writes change only the writable bits: all of Status, EPC, Context and EntryHi; Cause bits 23 and 9:8; IntCtl bits 9:5; EBase bits 31:12. BadVAddr cannot be written.
- R13: A software write in a strobe cycle is dropped entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_strobe_i | input | 1 | One-cycle exception request |
| exc_class_i | input | 2 | 0 general, 1 TLB refill, 2 interrupt |
| fault_kind_i | input | 3 | 0 other, 1 TLB miss, 2 TLB modified, 3 read inhibit, 4 execute inhibit |
| exc_code_i | input | 5 | Exception code used for fault kind 0 |
| cu_unit_i | input | 2 | Faulting unit number for code 11 |
| page_iec_i | input | 1 | Selects the dedicated inhibit codes |
| fetch_pc_i | input | 32 | PC at which the fault was seen |
| in_delay_slot_i | input | 1 | Faulting instruction is in a delay slot |
| fault_va_i | input | 32 | Faulting virtual address |
| is_store_i | input | 1 | Access was a store |
| sw_we_i | input | 1 | Software write enable |
| sw_sel_i | input | 3 | Software register select |
| sw_wdata_i | input | 32 | Software write data |
| sw_rdata_o | output | 32 | Software read data |
| new_pc_o | output | 32 | Exception target PC |
| new_pc_valid_o | output | 1 | New PC is valid this cycle |

## Verification
The hardest case to reach is a nested entry. An exception arrives while EXL is still set, so the vector must fall back to 0x180 and EPC and BD must stay as they were. The bench reaches it by issuing a second strobe without clearing Status in between, first as a TLB refill and later together with a software write to EPC. A second hard case is the interaction of the boot-vector bit with an interrupt that has IV set. The bench reaches it by programming Status, Cause and EBase through the software port before each interrupt strobe. The bench's reference model also checks every register through the read port after each step.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

   typedef enum logic [1:0] {
      CLS_GENERAL = 2'd0,
      CLS_REFILL  = 2'd1,
      CLS_INTR    = 2'd2
   } exc_class_e;

   typedef enum logic [2:0] {
      FK_OTHER    = 3'd0,
      FK_TLB_MISS = 3'd1,
      FK_TLB_MOD  = 3'd2,
      FK_RD_INH   = 3'd3,
      FK_EX_INH   = 3'd4
   } fault_kind_e;

   localparam int CODE_W = 5;

   localparam logic [CODE_W-1:0] EC_MOD   = 5'd1;
   localparam logic [CODE_W-1:0] EC_TLBL  = 5'd2;
   localparam logic [CODE_W-1:0] EC_TLBS  = 5'd3;
   localparam logic [CODE_W-1:0] EC_CPU   = 5'd11;
   localparam logic [CODE_W-1:0] EC_TLBRI = 5'd19;
   localparam logic [CODE_W-1:0] EC_TLBXI = 5'd20;

   localparam int NREG    = 8;
   localparam int SEL_W   = $clog2(NREG);
   localparam int RI_STAT = 0;
   localparam int RI_CAUS = 1;
   localparam int RI_ICTL = 2;
   localparam int RI_EBAS = 3;
   localparam int RI_EPC  = 4;
   localparam int RI_BADV = 5;
   localparam int RI_CTX  = 6;
   localparam int RI_EHI  = 7;

   localparam int ST_EXL  = 1;
   localparam int ST_BEV  = 22;
   localparam int CA_BD   = 31;
   localparam int CA_IV   = 23;
   localparam int CA_CE   = 28;
   localparam int CA_CODE = 2;
   localparam int CTX_VPN = 4;
   localparam int VPN_LSB = 13;

endpackage

// File: rtl/exc_code_resolve.sv
module exc_code_resolve
   import exc_entry_pkg::*;
(
   input  logic [2:0]        fault_kind,
   input  logic [CODE_W-1:0] raw_code,
   input  logic              is_store,
   input  logic              iec,
   output logic [CODE_W-1:0] code,
   output logic              cap_badva,
   output logic              cap_vpn
);

   fault_kind_e kind;
   assign kind = fault_kind_e'(fault_kind);

   always_comb begin
      code      = raw_code;
      cap_badva = 1'b0;
      cap_vpn   = 1'b0;
      case (kind)
         FK_TLB_MISS: begin
            code      = is_store ? EC_TLBS : EC_TLBL;
            cap_badva = 1'b1;
            cap_vpn   = 1'b1;
         end
         FK_TLB_MOD: begin
            code      = EC_MOD;
            cap_badva = 1'b1;
            cap_vpn   = 1'b1;
         end
         FK_RD_INH: begin
            code      = iec ? EC_TLBRI : EC_TLBL;
            cap_badva = 1'b1;
            cap_vpn   = 1'b1;
         end
         FK_EX_INH: begin
            code      = iec ? EC_TLBXI : EC_TLBL;
            cap_vpn   = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
   import exc_entry_pkg::*;
#(
   parameter int              AW          = 32,
   parameter int              EBASE_LSB   = 12,
   parameter logic [AW-1:0]   BOOT_BASE   = 32'hBFC0_0200,
   parameter logic [AW-1:0]   OFF_REFILL  = 32'h0000_0000,
   parameter logic [AW-1:0]   OFF_GENERAL = 32'h0000_0180,
   parameter logic [AW-1:0]   OFF_INTVEC  = 32'h0000_0200
)(
   input  logic                    exl,
   input  logic                    bev,
   input  logic                    iv,
   input  logic [1:0]              cls,
   input  logic [AW-1:EBASE_LSB]   ebase_field,
   output logic [AW-1:0]           target
);

   localparam int LOW_W = AW - 2;

   exc_class_e      cls_e;
   logic [AW-1:0]   offset;
   logic [AW-1:0]   base;
   logic [LOW_W-1:0] low_sum;

   assign cls_e = exc_class_e'(cls);

   always_comb begin
      if (exl) begin
         offset = OFF_GENERAL;
      end else begin
         case (cls_e)
            CLS_REFILL: offset = OFF_REFILL;
            CLS_INTR:   offset = iv ? OFF_INTVEC : OFF_GENERAL;
            default:    offset = OFF_GENERAL;
         endcase
      end
   end

   assign base    = bev ? BOOT_BASE : {ebase_field, {EBASE_LSB{1'b0}}};
   assign low_sum = base[LOW_W-1:0] + offset[LOW_W-1:0];
   assign target  = {base[AW-1:LOW_W], low_sum};

endmodule

// File: rtl/exc_cop0_regs.sv
module exc_cop0_regs
   import exc_entry_pkg::*;
#(
   parameter int            AW         = 32,
   parameter bit            READ_REG   = 1'b0,
   parameter logic [AW-1:0] STATUS_RST = 32'h0040_0000
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_we,
   input  logic [SEL_W-1:0]  sw_sel,
   input  logic [AW-1:0]     sw_wdata,
   output logic [AW-1:0]     sw_rdata,
   input  logic              exc_take,
   input  logic [CODE_W-1:0] exc_code,
   input  logic [1:0]        ce_val,
   input  logic              in_delay,
   input  logic [AW-1:0]     fetch_pc,
   input  logic [AW-1:0]     fault_va,
   input  logic              cap_badva,
   input  logic              cap_vpn,
   output logic [AW-1:0]     status_q,
   output logic [AW-1:0]     cause_q,
   output logic [AW-1:0]     ebase_q,
   output logic [AW-1:0]     epc_q
);

   localparam int VPN_W = AW - VPN_LSB;

   function automatic logic [AW-1:0] wr_mask(input int idx);
      case (idx)
         RI_CAUS: wr_mask = AW'(32'h0080_0300);
         RI_ICTL: wr_mask = AW'(32'h0000_03E0);
         RI_EBAS: wr_mask = AW'(32'hFFFF_F000);
         RI_BADV: wr_mask = '0;
         default: wr_mask = '1;
      endcase
   endfunction

   function automatic logic [AW-1:0] rst_val(input int idx);
      rst_val = (idx == RI_STAT) ? STATUS_RST : '0;
   endfunction

   logic [AW-1:0] regs_q [NREG];
   logic [AW-1:0] regs_d [NREG];
   logic          exl_now;

   assign exl_now = regs_q[RI_STAT][ST_EXL];

   always_comb begin
      for (int i = 0; i < NREG; i++) regs_d[i] = regs_q[i];
      if (exc_take) begin
         regs_d[RI_STAT][ST_EXL]                   = 1'b1;
         regs_d[RI_CAUS][CA_CODE +: CODE_W]        = exc_code;
         regs_d[RI_CAUS][CA_CE +: 2]               = ce_val;
         if (!exl_now) begin
            regs_d[RI_CAUS][CA_BD] = in_delay;
            regs_d[RI_EPC]         = fetch_pc - (in_delay ? AW'(8) : AW'(4));
         end
         if (cap_badva) regs_d[RI_BADV] = fault_va;
         if (cap_vpn) begin
            regs_d[RI_CTX][CTX_VPN +: VPN_W] = fault_va[AW-1:VPN_LSB];
            regs_d[RI_EHI][AW-1:VPN_LSB]     = fault_va[AW-1:VPN_LSB];
         end
      end else if (sw_we) begin
         for (int i = 0; i < NREG; i++) begin
            if (sw_sel == SEL_W'(i))
               regs_d[i] = (regs_q[i] & ~wr_mask(i)) | (sw_wdata & wr_mask(i));
         end
      end
   end

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) regs_q[g] <= rst_val(g);
         else        regs_q[g] <= regs_d[g];
      end
   end

   if (READ_REG) begin : g_rd_flop
      always_ff @(posedge clk) begin
         if (!rst_n) sw_rdata <= '0;
         else        sw_rdata <= regs_q[sw_sel];
      end
   end else begin : g_rd_comb
      assign sw_rdata = regs_q[sw_sel];
   end

   assign status_q = regs_q[RI_STAT];
   assign cause_q  = regs_q[RI_CAUS];
   assign ebase_q  = regs_q[RI_EBAS];
   assign epc_q    = regs_q[RI_EPC];

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
   import exc_entry_pkg::*;
#(
   parameter int            AW          = 32,
   parameter int            EBASE_LSB   = 12,
   parameter bit            READ_REG    = 1'b0,
   parameter logic [AW-1:0] RESET_PC    = 32'hBFC0_0000,
   parameter logic [AW-1:0] BOOT_BASE   = 32'hBFC0_0200,
   parameter logic [AW-1:0] STATUS_RST  = 32'h0040_0000
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           exc_strobe_i,
   input  logic [1:0]     exc_class_i,
   input  logic [2:0]     fault_kind_i,
   input  logic [4:0]     exc_code_i,
   input  logic [1:0]     cu_unit_i,
   input  logic           page_iec_i,
   input  logic [31:0]    fetch_pc_i,
   input  logic           in_delay_slot_i,
   input  logic [31:0]    fault_va_i,
   input  logic           is_store_i,
   input  logic           sw_we_i,
   input  logic [2:0]     sw_sel_i,
   input  logic [31:0]    sw_wdata_i,
   output logic [31:0]    sw_rdata_o,
   output logic [31:0]    new_pc_o,
   output logic           new_pc_valid_o
);

   if (AW != 32) begin : g_aw_bad
      $error("exc_entry_unit: AW must be 32");
   end
   if (EBASE_LSB < 10 || EBASE_LSB > 20) begin : g_eb_bad
      $error("exc_entry_unit: EBASE_LSB out of range");
   end
   if (STATUS_RST[ST_EXL] != 1'b0) begin : g_rst_bad
      $error("exc_entry_unit: reset Status must have EXL clear");
   end

   logic [CODE_W-1:0] code_res;
   logic              cap_badva;
   logic              cap_vpn;
   logic [AW-1:0]     status_q;
   logic [AW-1:0]     cause_q;
   logic [AW-1:0]     ebase_q;
   logic [AW-1:0]     epc_q;
   logic [AW-1:0]     target;
   logic [1:0]        ce_val;
   logic [AW-1:0]     pc_q;
   logic              vld_q;

   exc_code_resolve u_code (
      .fault_kind (fault_kind_i),
      .raw_code   (exc_code_i),
      .is_store   (is_store_i),
      .iec        (page_iec_i),
      .code       (code_res),
      .cap_badva  (cap_badva),
      .cap_vpn    (cap_vpn)
   );

   assign ce_val = (code_res == EC_CPU) ? cu_unit_i : 2'b00;

   exc_cop0_regs #(
      .AW         (AW),
      .READ_REG   (READ_REG),
      .STATUS_RST (STATUS_RST)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_we     (sw_we_i),
      .sw_sel    (sw_sel_i),
      .sw_wdata  (sw_wdata_i),
      .sw_rdata  (sw_rdata_o),
      .exc_take  (exc_strobe_i),
      .exc_code  (code_res),
      .ce_val    (ce_val),
      .in_delay  (in_delay_slot_i),
      .fetch_pc  (fetch_pc_i),
      .fault_va  (fault_va_i),
      .cap_badva (cap_badva),
      .cap_vpn   (cap_vpn),
      .status_q  (status_q),
      .cause_q   (cause_q),
      .ebase_q   (ebase_q),
      .epc_q     (epc_q)
   );

   exc_vector_gen #(
      .AW        (AW),
      .EBASE_LSB (EBASE_LSB),
      .BOOT_BASE (BOOT_BASE)
   ) u_vec (
      .exl         (status_q[ST_EXL]),
      .bev         (status_q[ST_BEV]),
      .iv          (cause_q[CA_IV]),
      .cls         (exc_class_i),
      .ebase_field (ebase_q[AW-1:EBASE_LSB]),
      .target      (target)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q  <= RESET_PC;
         vld_q <= 1'b0;
      end else begin
         vld_q <= exc_strobe_i;
         if (exc_strobe_i) pc_q <= target;
      end
   end

   assign new_pc_o       = pc_q;
   assign new_pc_valid_o = vld_q;

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
   parameter logic [31:0] BOOT_BASE = 32'hBFC0_0200
)(
   input logic        clk,
   input logic        rst_n,
   input logic        exc_strobe_i,
   input logic [31:0] fetch_pc_i,
   input logic        in_delay_slot_i,
   input logic [31:0] status_q,
   input logic [31:0] cause_q,
   input logic [31:0] ebase_q,
   input logic [31:0] epc_q,
   input logic [31:0] new_pc_o,
   input logic        new_pc_valid_o
);

   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_strobe_i |=> new_pc_valid_o);

   // R2
   valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_strobe_i |=> !new_pc_valid_o);

   // R3
   epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_strobe_i && !status_q[1]) |=>
         epc_q == ($past(fetch_pc_i) - ($past(in_delay_slot_i) ? 32'd8 : 32'd4)));

   // R3
   bd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_strobe_i && !status_q[1]) |=> cause_q[31] == $past(in_delay_slot_i));

   // R4
   nested_epc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_strobe_i && status_q[1]) |=> ($stable(epc_q) && $stable(cause_q[31])));

   // R7
   pc_top_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_strobe_i |=> new_pc_o[31:30] ==
         ($past(status_q[22]) ? BOOT_BASE[31:30] : $past(ebase_q[31:30])));

   // R8
   exl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_strobe_i |=> status_q[1]);

endmodule

bind exc_entry_unit exc_entry_chk #(.BOOT_BASE(BOOT_BASE)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .exc_strobe_i    (exc_strobe_i),
   .fetch_pc_i      (fetch_pc_i),
   .in_delay_slot_i (in_delay_slot_i),
   .status_q        (status_q),
   .cause_q         (cause_q),
   .ebase_q         (ebase_q),
   .epc_q           (epc_q),
   .new_pc_o        (new_pc_o),
   .new_pc_valid_o  (new_pc_valid_o)
);

// File: tb/exc_entry_unit_bench.sv
`timescale 1ns/1ps
module exc_entry_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exc_strobe_i = 1'b0;
   logic [1:0]  exc_class_i = '0;
   logic [2:0]  fault_kind_i = '0;
   logic [4:0]  exc_code_i = '0;
   logic [1:0]  cu_unit_i = '0;
   logic        page_iec_i = 1'b0;
   logic [31:0] fetch_pc_i = '0;
   logic        in_delay_slot_i = 1'b0;
   logic [31:0] fault_va_i = '0;
   logic        is_store_i = 1'b0;
   logic        sw_we_i = 1'b0;
   logic [2:0]  sw_sel_i = '0;
   logic [31:0] sw_wdata_i = '0;
   logic [31:0] sw_rdata_o;
   logic [31:0] new_pc_o;
   logic        new_pc_valid_o;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   exc_entry_unit u_exc_entry_unit (.*);

   // reference model state
   logic [31:0] m_reg [8];
   logic [31:0] m_pc;
   logic        m_vld;
   logic [31:0] nx [8];
   logic [31:0] nx_pc;

   function automatic logic [31:0] m_mask(input int i);
      case (i)
         1: return 32'h0080_0300;
         2: return 32'h0000_03E0;
         3: return 32'hFFFF_F000;
         5: return 32'h0;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   function automatic logic [4:0] m_code(input int kind, input logic [4:0] c,
                                         input logic st, input logic iec);
      case (kind)
         1: return st ? 5'd3 : 5'd2;
         2: return 5'd1;
         3: return iec ? 5'd19 : 5'd2;
         4: return iec ? 5'd20 : 5'd2;
         default: return c;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) m_reg[i] <= 32'h0;
         m_reg[0] <= 32'h0040_0000;
         m_pc  <= 32'hBFC0_0000;
         m_vld <= 1'b0;
      end else begin
         for (int i = 0; i < 8; i++) nx[i] = m_reg[i];
         nx_pc = m_pc;
         if (exc_strobe_i) begin
            automatic logic exl = m_reg[0][1];
            automatic int off = 'h180;
            automatic logic [31:0] base;
            automatic logic [4:0] cd = m_code(int'(fault_kind_i), exc_code_i,
                                             is_store_i, page_iec_i);
            if (!exl && exc_class_i == 2'd1) off = 0;
            if (!exl && exc_class_i == 2'd2 && m_reg[1][23]) off = 'h200;
            base = m_reg[0][22] ? 32'hBFC0_0200 : (m_reg[3] & 32'hFFFF_F000);
            nx_pc = (base & 32'hC000_0000) |
                    (((base & 32'h3FFF_FFFF) + off) & 32'h3FFF_FFFF);
            nx[0] = nx[0] | 32'h2;
            nx[1] = (nx[1] & ~32'h3000_007C) | (32'(cd) << 2) |
                    ((cd == 5'd11) ? (32'(cu_unit_i) << 28) : 32'h0);
            if (!exl) begin
               nx[1] = in_delay_slot_i ? (nx[1] | 32'h8000_0000) : (nx[1] & 32'h7FFF_FFFF);
               nx[4] = fetch_pc_i - (in_delay_slot_i ? 8 : 4);
            end
            if (fault_kind_i inside {3'd1, 3'd2, 3'd3}) nx[5] = fault_va_i;
            if (fault_kind_i inside {3'd1, 3'd2, 3'd3, 3'd4}) begin
               nx[6] = (nx[6] & ~32'h007F_FFF0) | ((fault_va_i >> 13) << 4);
               nx[7] = (nx[7] & 32'h0000_1FFF) | (fault_va_i & 32'hFFFF_E000);
            end
         end else if (sw_we_i) begin
            nx[sw_sel_i] = (m_reg[sw_sel_i] & ~m_mask(int'(sw_sel_i))) |
                           (sw_wdata_i & m_mask(int'(sw_sel_i)));
         end
         for (int i = 0; i < 8; i++) m_reg[i] <= nx[i];
         m_pc  <= nx_pc;
         m_vld <= exc_strobe_i;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // per-cycle comparison against the model (R2, R12)
   always begin
      @(posedge clk);
      #3;
      if (rst_n) begin
         chk("R2 new_pc", new_pc_o, m_pc);
         chk("R2 valid", 32'(new_pc_valid_o), 32'(m_vld));
         chk("R12 read", sw_rdata_o, m_reg[sw_sel_i]);
      end
   end

   task automatic rd(input int sel, output logic [31:0] v);
      sw_sel_i = sel[2:0];
      #1;
      v = sw_rdata_o;
   endtask

   task automatic wr(input int sel, input logic [31:0] d);
      @(negedge clk);
      sw_we_i = 1'b1; sw_sel_i = sel[2:0]; sw_wdata_i = d;
      @(negedge clk);
      sw_we_i = 1'b0;
   endtask

   task automatic exc(input int cls, input int kind, input int code, input logic [31:0] pc,
                      input logic dly, input logic [31:0] va, input logic st,
                      input logic iec, input int cu, input logic we, input int wsel,
                      input logic [31:0] wd);
      @(negedge clk);
      exc_strobe_i = 1'b1; exc_class_i = cls[1:0]; fault_kind_i = kind[2:0];
      exc_code_i = code[4:0]; fetch_pc_i = pc; in_delay_slot_i = dly;
      fault_va_i = va; is_store_i = st; page_iec_i = iec; cu_unit_i = cu[1:0];
      sw_we_i = we; sw_sel_i = wsel[2:0]; sw_wdata_i = wd;
      @(negedge clk);
      exc_strobe_i = 1'b0; sw_we_i = 1'b0;
   endtask

   task automatic all_regs(input string req);
      logic [31:0] v;
      for (int i = 0; i < 8; i++) begin
         rd(i, v);
         chk(req, v, m_reg[i]);
      end
   endtask

   initial begin
      #(200000 * 10);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(0, v); chk("R1 status", v, 32'h0040_0000);
      for (int i = 1; i < 8; i++) begin rd(i, v); chk("R1 zero", v, 32'h0); end
      chk("R1 pc", new_pc_o, 32'hBFC0_0000);
      chk("R1 valid", 32'(new_pc_valid_o), 32'h0);

      // R3 R6 R8: boot vectors, general exception, no delay slot
      exc(0, 0, 8, 32'h0000_1000, 1'b0, 32'h0, 1'b0, 1'b0, 0, 1'b0, 0, 32'h0);
      chk("R2 valid pulse", 32'(new_pc_valid_o), 32'h1);
      chk("R6 boot general", new_pc_o, 32'hBFC0_0380);
      rd(4, v); chk("R3 epc", v, 32'h0000_0FFC);
      rd(1, v); chk("R8 code", v, 32'h0000_0020);
      rd(0, v); chk("R8 exl", v, 32'h0040_0002);
      @(negedge clk);
      chk("R2 valid drop", 32'(new_pc_valid_o), 32'h0);

      // R3 R6 delay slot, EBase vector
      wr(0, 32'h0);
      wr(3, 32'h8000_1234);
      rd(3, v); chk("R12 ebase mask", v, 32'h8000_1000);
      exc(0, 0, 12, 32'h0000_2008, 1'b1, 32'h0, 1'b0, 1'b0, 0, 1'b0, 0, 32'h0);
      chk("R6 ebase general", new_pc_o, 32'h8000_1180);
      rd(4, v); chk("R3 epc delay", v, 32'h0000_2000);
      rd(1, v); chk("R3 bd", v, 32'h8000_0030);

      // R4 nested refill keeps EPC/BD and uses 0x180; R10 R11 store miss
      exc(1, 1, 0, 32'h0000_3000, 1'b0, 32'h1234_5678, 1'b1, 1'b0, 0, 1'b0, 0, 32'h0);
      chk("R4 nested offset", new_pc_o, 32'h8000_1180);
      rd(4, v); chk("R4 epc held", v, 32'h0000_2000);
      rd(1, v); chk("R4 bd held / R10 TLBS", v, 32'h8000_000C);
      rd(5, v); chk("R11 badva", v, 32'h1234_5678);
      rd(6, v); chk("R11 context", v, 32'h0009_1A20);
      rd(7, v); chk("R11 entryhi", v, 32'h1234_4000);

      // R5 R11 refill at offset 0, other bits preserved, load
      wr(0, 32'h0);
      wr(6, 32'hFFFF_FFFF);
      wr(7, 32'h0000_00FF);
      exc(1, 1, 0, 32'h0000_4000, 1'b0, 32'hABCD_E000, 1'b0, 1'b0, 0, 1'b0, 0, 32'h0);
      chk("R5 refill", new_pc_o, 32'h8000_1000);
      rd(6, v); chk("R11 context keep", v, 32'hFFD5_E6FF);
      rd(7, v); chk("R11 entryhi keep", v, 32'hABCD_E0FF);
      rd(1, v); chk("R10 TLBL", v & 32'h7C, 32'h08);

      // R5 interrupts
      wr(0, 32'h0);
      exc(2, 0, 0, 32'h0000_5000, 1'b0, 32'h0, 1'b0, 1'b0, 0, 1'b0, 0, 32'h0);
      chk("R5 int iv0", new_pc_o, 32'h8000_1180);
      wr(0, 32'h0);
      wr(1, 32'hFFFF_FFFF);
      rd(1, v); chk("R12 cause mask", v, 32'h0080_0300);
      wr(2, 32'h0000_0020);
      exc(2, 0, 0, 32'h0000_5000, 1'b0, 32'h0, 1'b0, 1'b0, 0, 1'b0, 0, 32'h0);
      chk("R5 int iv1", new_pc_o, 32'h8000_1200);
      rd(1, v); chk("R8 iv kept", v, 32'h0080_0300);
      wr(0, 32'h0040_0000);
      exc(2, 0, 0, 32'h0000_5000, 1'b0, 32'h0, 1'b0, 1'b0, 0, 1'b0, 0, 32'h0);
      chk("R5 int boot", new_pc_o, 32'hBFC0_0400);

      // R7 top bits kept
      wr(0, 32'h0);
      wr(3, 32'hC000_0000);
      exc(0, 0, 9, 32'h0000_6000, 1'b0, 32'h0, 1'b0, 1'b0, 0, 1'b0, 0, 32'h0);
      chk("R7 top 11", new_pc_o, 32'hC000_0180);
      wr(0, 32'h0);
      wr(3, 32'h7FFF_F000);
      exc(1, 0, 4, 32'h0000_6000, 1'b0, 32'h0, 1'b0, 1'b0, 0, 1'b0, 0, 32'h0);
      chk("R7 top 01", new_pc_o, 32'h7FFF_F000);

      // R9 coprocessor unit field
      wr(0, 32'h0);
      exc(0, 0, 11, 32'h0000_7000, 1'b0, 32'h0, 1'b0, 1'b0, 2, 1'b0, 0, 32'h0);
      rd(1, v); chk("R9 ce set", (v >> 28) & 32'h3, 32'h2);
      exc(0, 0, 10, 32'h0000_7000, 1'b0, 32'h0, 1'b0, 1'b0, 3, 1'b0, 0, 32'h0);
      rd(1, v); chk("R9 ce clear", (v >> 28) & 32'h3, 32'h0);
      chk("R8 code replace", (v >> 2) & 32'h1F, 32'd10);

      // R10 R11 inhibit faults and modified
      exc(0, 3, 0, 32'h0, 1'b0, 32'h1111_1000, 1'b0, 1'b0, 0, 1'b0, 0, 32'h0);
      rd(1, v); chk("R10 rd-inh iec0", (v >> 2) & 32'h1F, 32'd2);
      exc(0, 3, 0, 32'h0, 1'b0, 32'h2222_2000, 1'b0, 1'b1, 0, 1'b0, 0, 32'h0);
      rd(1, v); chk("R10 rd-inh iec1", (v >> 2) & 32'h1F, 32'd19);
      exc(0, 4, 0, 32'h0, 1'b0, 32'h3333_3000, 1'b0, 1'b1, 0, 1'b0, 0, 32'h0);
      rd(1, v); chk("R10 ex-inh iec1", (v >> 2) & 32'h1F, 32'd20);
      rd(5, v); chk("R11 ex-inh no badva", v, 32'h2222_2000);
      exc(0, 2, 0, 32'h0, 1'b0, 32'h4444_4000, 1'b0, 1'b0, 0, 1'b0, 0, 32'h0);
      rd(1, v); chk("R10 mod", (v >> 2) & 32'h1F, 32'd1);

      // R12 BadVAddr read-only
      wr(5, 32'h0);
      rd(5, v); chk("R12 badva ro", v, 32'h4444_4000);

      // R13 software write dropped in strobe cycle (EXL still 1)
      exc(0, 0, 13, 32'h0000_8000, 1'b0, 32'h0, 1'b0, 1'b0, 0, 1'b1, 4, 32'hDEAD_0000);
      rd(4, v); chk("R13 epc", v, m_reg[4]);
      chk("R13 epc not written", 32'(v == 32'hDEAD_0000), 32'h0);
      wr(0, 32'h0);
      exc(0, 0, 13, 32'h0000_9000, 1'b0, 32'h0, 1'b0, 1'b0, 0, 1'b1, 3, 32'h0000_0000);
      rd(3, v); chk("R13 ebase kept", v, 32'h7FFF_F000);

      all_regs("R12 final");
      repeat (2) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule